// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between an on-chip request port and one external asynchronous static RAM of 32768 bytes. A client raises a request with an address, a direction and (for stores) a data byte. The block then steps the memory's active-low chip-select, output-enable and write-strobe pins through a fixed order. Each phase is held for a number of clock cycles taken from configuration inputs, so that the memory's access time, write-pulse width and bus-release time are met at any clock rate. Completion is signalled by a single-cycle acknowledge, and load data comes back on a registered output.

The external data bus is shared and bidirectional. Here it is split into an outgoing byte, an incoming byte and a drive enable, and the pad is left to the surrounding chip. The memory may only drive the bus while chip-select and output-enable are low and the write strobe is high. The block drives it only during a store, and only with output-enable high. A store that comes right after a load first waits out a programmable gap with every strobe inactive, which gives the memory's output time to return to high impedance.

Every strobe and bus-control output comes straight from a flop. When no access is in progress, chip-select is high and the memory is in standby.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, and in every idle cycle, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0 and `ack` is 0.
- R2: The block accepts a load (`req`=1, `req_write`=0) on a clock edge while idle. For the next `cfg_rd` cycles it holds `mem_ce_n`=0, `mem_oe_n`=0, `mem_we_n`=1 and `mem_dq_oe`=0.
- R3: The block accepts a store (`req`=1, `req_write`=1) on a clock edge while idle, and then holds `mem_ce_n`=0 and `mem_oe_n`=1 for `cfg_su`+`cfg_wp` cycles. For those cycles `mem_dq_oe`=1 and `mem_dq_out` carries the accepted byte. `mem_we_n` is 0 in the final `cfg_wp` of them and 1 before.
- R4: `mem_dq_oe` is never 1 in a cycle where `mem_oe_n` is 0, so the block and the memory never drive the bus together.
- R5: When the most recent accepted access was a load, a store first spends `cfg_ta` cycles with all strobes inactive and `mem_dq_oe`=0. A store after reset or after another store starts its setup phase at once.
- R6: `ack` is 1 for exactly one cycle, the cycle right after the last strobe-active cycle. In that cycle all three strobes are 1 and `mem_dq_oe` is 0.
- R7: The block ignores requests outside idle. While `mem_ce_n` stays 0, `mem_addr` and `mem_dq_out` keep the values latched at acceptance, whatever the request inputs do.
- R8: `mem_we_n` is 0 only while `mem_ce_n` is 0 and `mem_oe_n` is 1.
- R9: A configured count of 0 behaves exactly as a count of 1.
- R10: `rdata` takes the byte on `mem_dq_in` in the last load-access cycle. It is valid in the `ack` cycle and holds until the next load completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rd | input | 4 | Load access length in cycles |
| cfg_su | input | 4 | Store setup length (select and data before write strobe) |
| cfg_wp | input | 4 | Write strobe low length |
| cfg_ta | input | 4 | Gap inserted before a store that follows a load |
| req | input | 1 | Request valid, sampled while idle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 15 | Request byte address |
| req_wdata | input | 8 | Store data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Load data |
| mem_addr | output | 15 | Memory address bus |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 8 | Byte read from the data bus |

## Verification
Some rules hold on every clock, and properties check them there: the bus is never driven with output-enable low, the write strobe is low only inside chip-select with output-enable high, acknowledge never lasts two cycles, address and store data stay stable while selected, and each write strobe lasts exactly its configured width. Other behaviour only shows up in the bench's scenarios, which compare the full per-cycle strobe pattern with a model built from the configured counts. These are the phase lengths, the turnaround gap appearing only after a load, counts of zero, request inputs changing mid-access, and data written and then read back through a behavioural memory.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_ACC   = 3'd1,
        ST_RD_CAP   = 3'd2,
        ST_TURN     = 3'd3,
        ST_WR_SU    = 3'd4,
        ST_WR_PULSE = 3'd5,
        ST_WR_REL   = 3'd6
    } seq_st_e;

    typedef struct packed {
        seq_st_e st;
        logic    ce_n;
        logic    oe_n;
        logic    we_n;
        logic    dq_oe;
        logic    ack;
        logic    last_rd;
    } seq_regs_t;

    localparam seq_regs_t SEQ_RESET = '{
        st: ST_IDLE, ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
        dq_oe: 1'b0, ack: 1'b0, last_rd: 1'b0
    };

endpackage

// File: rtl/asram_ivl.sv
module asram_ivl #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] eff_val;

    always_comb begin
        eff_val = (load_val == '0) ? CNT_W'(1) : load_val;
        if (load)
            cnt_d = eff_val - CNT_W'(1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - CNT_W'(1);
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R9: a load always leaves the counter below the programmed length
    p_load_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q < eff_val || $past(load_val) == '0 || cnt_q == $past(eff_val) - CNT_W'(1)));

endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_write,
    input  logic [CNT_W-1:0] cfg_rd,
    input  logic [CNT_W-1:0] cfg_su,
    input  logic [CNT_W-1:0] cfg_wp,
    input  logic [CNT_W-1:0] cfg_ta,
    input  logic             expired,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_val,
    output logic             addr_ld,
    output logic             wd_ld,
    output logic             cap,
    output logic             ce_n,
    output logic             oe_n,
    output logic             we_n,
    output logic             dq_oe,
    output logic             ack
);
    seq_regs_t d, q;

    always_comb begin
        d        = q;
        d.ack    = 1'b0;
        cnt_load = 1'b0;
        cnt_val  = '0;
        addr_ld  = 1'b0;
        wd_ld    = 1'b0;
        cap      = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req) begin
                    addr_ld  = 1'b1;
                    cnt_load = 1'b1;
                    if (!req_write) begin
                        d.st      = ST_RD_ACC;
                        cnt_val   = cfg_rd;
                        d.ce_n    = 1'b0;
                        d.oe_n    = 1'b0;
                        d.last_rd = 1'b1;
                    end else begin
                        wd_ld     = 1'b1;
                        d.last_rd = 1'b0;
                        if (q.last_rd) begin
                            d.st    = ST_TURN;
                            cnt_val = cfg_ta;
                        end else begin
                            d.st    = ST_WR_SU;
                            cnt_val = cfg_su;
                            d.ce_n  = 1'b0;
                            d.dq_oe = 1'b1;
                        end
                    end
                end
            end
            ST_RD_ACC: begin
                if (expired) begin
                    d.st   = ST_RD_CAP;
                    d.ce_n = 1'b1;
                    d.oe_n = 1'b1;
                    d.ack  = 1'b1;
                    cap    = 1'b1;
                end
            end
            ST_RD_CAP: d.st = ST_IDLE;
            ST_TURN: begin
                if (expired) begin
                    d.st     = ST_WR_SU;
                    cnt_load = 1'b1;
                    cnt_val  = cfg_su;
                    d.ce_n   = 1'b0;
                    d.dq_oe  = 1'b1;
                end
            end
            ST_WR_SU: begin
                if (expired) begin
                    d.st     = ST_WR_PULSE;
                    cnt_load = 1'b1;
                    cnt_val  = cfg_wp;
                    d.we_n   = 1'b0;
                end
            end
            ST_WR_PULSE: begin
                if (expired) begin
                    d.st    = ST_WR_REL;
                    d.we_n  = 1'b1;
                    d.ce_n  = 1'b1;
                    d.dq_oe = 1'b0;
                    d.ack   = 1'b1;
                end
            end
            ST_WR_REL: d.st = ST_IDLE;
            default: d = SEQ_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEQ_RESET;
        else        q <= d;
    end

    assign ce_n  = q.ce_n;
    assign oe_n  = q.oe_n;
    assign we_n  = q.we_n;
    assign dq_oe = q.dq_oe;
    assign ack   = q.ack;

    // checker: length of the current write strobe
    logic [CNT_W:0]   wlow_q;
    logic [CNT_W-1:0] wp_eff;
    assign wp_eff = (cfg_wp == '0) ? CNT_W'(1) : cfg_wp;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     wlow_q <= '0;
        else if (!we_n) wlow_q <= wlow_q + 1'b1;
        else            wlow_q <= '0;
    end

    p_no_contention_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> oe_n);
    p_we_in_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (!ce_n && oe_n));
    p_ack_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    p_ack_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (ce_n && oe_n && we_n && !dq_oe));
    p_wp_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (wlow_q == {1'b0, wp_eff}));

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_ld,
    input  logic              wd_ld,
    input  logic              cap,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic [DATA_W-1:0] rdata
);
    logic [ADDR_W-1:0] addr_d, addr_q;
    logic [DATA_W-1:0] wd_d, wd_q;
    logic [DATA_W-1:0] rd_d, rd_q;

    always_comb begin
        addr_d = addr_ld ? req_addr  : addr_q;
        wd_d   = wd_ld   ? req_wdata : wd_q;
        rd_d   = cap     ? mem_dq_in : rd_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            wd_q   <= '0;
            rd_q   <= '0;
        end else begin
            addr_q <= addr_d;
            wd_q   <= wd_d;
            rd_q   <= rd_d;
        end
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wd_q;
    assign rdata      = rd_q;

    // R10: load data only moves on a capture
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cap) |-> $stable(rdata));

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cfg_rd,
    input  logic [CNT_W-1:0]  cfg_su,
    input  logic [CNT_W-1:0]  cfg_wp,
    input  logic [CNT_W-1:0]  cfg_ta,
    input  logic              req,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    logic             expired, cnt_load, addr_ld, wd_ld, cap;
    logic [CNT_W-1:0] cnt_val;

    asram_ivl #(.CNT_W(CNT_W)) ivl_i (
        .clk(clk), .rst_n(rst_n), .load(cnt_load),
        .load_val(cnt_val), .expired(expired)
    );

    asram_seq #(.CNT_W(CNT_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
        .cfg_rd(cfg_rd), .cfg_su(cfg_su), .cfg_wp(cfg_wp), .cfg_ta(cfg_ta),
        .expired(expired), .cnt_load(cnt_load), .cnt_val(cnt_val),
        .addr_ld(addr_ld), .wd_ld(wd_ld), .cap(cap),
        .ce_n(mem_ce_n), .oe_n(mem_oe_n), .we_n(mem_we_n),
        .dq_oe(mem_dq_oe), .ack(ack)
    );

    asram_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath_i (
        .clk(clk), .rst_n(rst_n), .addr_ld(addr_ld), .wd_ld(wd_ld),
        .cap(cap), .req_addr(req_addr), .req_wdata(req_wdata),
        .mem_dq_in(mem_dq_in), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .rdata(rdata)
    );

    p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));
    p_wdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

endmodule

// File: tb/asram_ctrl_tb_top.sv
module asram_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_rd = 4'd2, cfg_su = 4'd1, cfg_wp = 4'd2, cfg_ta = 4'd2;
    logic        req = 1'b0, req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ack;
    logic [7:0]  rdata;
    logic [14:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hA5;

    int checks = 0;
    int fails  = 0;
    bit last_rd = 1'b0;
    logic [7:0] model_mem [int];
    logic [7:0] ref_mem   [int];

    always #5 clk = ~clk;

    asram_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_rd(cfg_rd), .cfg_su(cfg_su),
        .cfg_wp(cfg_wp), .cfg_ta(cfg_ta), .req(req), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rdata(rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    function automatic int eff(input logic [3:0] v);
        return (v == 4'd0) ? 1 : int'(v);
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // behavioural memory: drives the bus, commits writes, checks strobe rules
    logic        we_prev = 1'b1;
    logic [14:0] addr_prev = '0;
    logic [7:0]  dq_prev = '0;
    int          wlow = 0;
    int          exp_wp = 1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_ce_n && !mem_oe_n && mem_we_n && mem_dq_oe)
                chk(1'b0, "R4", "bus contention", 1, 0);
            if (!mem_we_n)
                chk(!mem_ce_n && mem_oe_n, "R8", "we low without ce/with oe",
                    {mem_ce_n, mem_oe_n}, 2'b01);
            if (!mem_we_n) wlow++;
            if (!we_prev && mem_we_n) begin
                chk(wlow == exp_wp, "R3", "write pulse width", wlow, exp_wp);
                model_mem[int'(addr_prev)] = dq_prev;
                wlow = 0;
            end
        end
        we_prev   = mem_we_n;
        addr_prev = mem_addr;
        dq_prev   = mem_dq_out;
        if (!mem_ce_n && !mem_oe_n && mem_we_n)
            mem_dq_in = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 8'h3C;
        else
            mem_dq_in = 8'hA5;
    end

    task automatic check_idle(input string tag);
        chk({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, ack} == 5'b11100, tag,
            "idle strobes", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, ack}, 5'b11100);
    endtask

    // one access; compares the strobe vector {ce_n,oe_n,we_n,dq_oe,ack} each cycle
    task automatic xact(input bit wr, input logic [14:0] a, input logic [7:0] dat,
                        input string tag);
        logic [4:0] expq[$];
        string      phq[$];
        if (!wr) begin
            for (int i = 0; i < eff(cfg_rd); i++) begin expq.push_back(5'b00100); phq.push_back("R2"); end
            expq.push_back(5'b11101); phq.push_back("R6");
        end else begin
            if (last_rd)
                for (int i = 0; i < eff(cfg_ta); i++) begin expq.push_back(5'b11100); phq.push_back("R5"); end
            for (int i = 0; i < eff(cfg_su); i++) begin expq.push_back(5'b01110); phq.push_back("R3"); end
            for (int i = 0; i < eff(cfg_wp); i++) begin expq.push_back(5'b01010); phq.push_back("R3"); end
            expq.push_back(5'b11101); phq.push_back("R6");
        end
        exp_wp = eff(cfg_wp);
        @(negedge clk);
        req = 1'b1; req_write = wr; req_addr = a; req_wdata = dat;
        for (int k = 0; k < expq.size(); k++) begin
            @(negedge clk);
            if (k == 0) begin
                req_addr  = ~a;   // R7: ignored while busy
                req_wdata = ~dat;
            end
            chk({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, ack} == expq[k],
                $sformatf("%s/%s", phq[k], tag), $sformatf("strobes cycle %0d", k),
                {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, ack}, expq[k]);
            if (!mem_ce_n)
                chk(mem_addr == a, $sformatf("R7/%s", tag), "address held", mem_addr, a);
            if (mem_dq_oe)
                chk(mem_dq_out == dat, $sformatf("R7/%s", tag), "store data held", mem_dq_out, dat);
            if (k == expq.size() - 1) begin
                if (!wr && ref_mem.exists(int'(a)))
                    chk(rdata == ref_mem[int'(a)], $sformatf("R10/%s", tag), "load data",
                        rdata, ref_mem[int'(a)]);
                req = 1'b0;
            end
        end
        if (wr) ref_mem[int'(a)] = dat;
        last_rd = !wr;
        @(negedge clk);
        check_idle($sformatf("R1/%s", tag));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1 reset");
        chk(rdata == 8'h00, "R1", "rdata after reset", rdata, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_idle("R1 after release");

        xact(1'b1, 15'h0000, 8'h11, "first store");
        xact(1'b1, 15'h7FFF, 8'hE7, "store after store");
        xact(1'b0, 15'h0000, 8'h00, "load low addr");
        xact(1'b0, 15'h7FFF, 8'h00, "load high addr");
        xact(1'b1, 15'h1234, 8'h5A, "R5 store after load");
        xact(1'b0, 15'h1234, 8'h00, "load back");
        // rdata held between loads (R10)
        repeat (3) @(negedge clk);
        chk(rdata == 8'h5A, "R10", "rdata held", rdata, 8'h5A);

        cfg_rd = 4'd5; cfg_su = 4'd3; cfg_wp = 4'd4; cfg_ta = 4'd3;
        xact(1'b1, 15'h0456, 8'hC3, "long store after load");
        xact(1'b0, 15'h0456, 8'h00, "long load");
        xact(1'b0, 15'h7FFF, 8'h00, "long load 2");

        cfg_rd = 4'd0; cfg_su = 4'd0; cfg_wp = 4'd0; cfg_ta = 4'd0;
        xact(1'b1, 15'h2AAA, 8'h96, "R9 zero counts store");
        xact(1'b0, 15'h2AAA, 8'h00, "R9 zero counts load");
        xact(1'b1, 15'h5555, 8'h69, "R9 zero counts turnaround");
        xact(1'b0, 15'h5555, 8'h00, "R9 zero counts load 2");

        cfg_rd = 4'd15; cfg_su = 4'd1; cfg_wp = 4'd15; cfg_ta = 4'd1;
        xact(1'b1, 15'h0001, 8'hFF, "max pulse store");
        xact(1'b0, 15'h0001, 8'h00, "max access load");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule